// File: doc/BRIEF.md
# Blanking-Drained Palette Write FIFO

This block queues colour-palette updates from the host side of a video lookup table. Each update has a 13-bit table index and a 24-bit colour. The updates wait in a 64-deep queue and are copied into the lookup banks only while the video blanking input is active. This keeps palette writes from disturbing visible pixels.

The host can push into a full queue. When it does, the block makes room by itself. It performs four transfers to the banks whatever the blanking state is. During those transfers it raises a hold output, so that the pixel path keeps showing its last good colour. The word that arrived while the queue was full is kept aside and appended in the cycle after the burst. The block reports its occupancy through three active-low flags: empty, full, and a threshold flag that a mode input switches between half and seven-eighths.

Top module: `pal_wr_fifo`

## Requirements
- R1: After reset the FIFO is empty: `empty_n`=0, `full_n`=1, `afull_n`=1, `bank_we`=0, `pix_hold`=0.
- R2: Entries reach the bank port in the order they were pushed. `bank_addr` and `bank_color` equal the pushed address and colour.
- R3: Outside a forced burst, an entry is transferred only in a cycle where `blank_n` is low.
  - During blanking, one entry leaves per clock.
  - `bank_we` is high for exactly one cycle per entry, with the entry's data on `bank_addr` and `bank_color` in that cycle.
- R4: `empty_n` is low exactly when no entries are held.
- R5: `full_n` is low exactly when 64 entries are held. It stays low until at least one entry has been transferred.
- R6: `afull_n` is active low.
  - With `afull_mode`=0 it is low when at least 32 entries are held.
  - With `afull_mode`=1 it is low when at least 56 entries are held.
- R7: A push while full starts a forced burst in the following cycle.
  - The burst transfers the 4 oldest entries on 4 consecutive cycles, even with `blank_n` high.
  - `pix_hold` is high in exactly those 4 cycles.
- R8: The word pushed while full is stored in the cycle after the fourth forced transfer. It is placed behind all older entries. Pushes offered while a forced burst or its pending write is in progress are not accepted.
- R9: A push and a transfer in the same cycle leave the number of held entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Host offers one palette update this cycle |
| push_addr | input | 13 | Table index of the update |
| push_color | input | 24 | Colour of the update |
| blank_n | input | 1 | Video blanking, low while blanked |
| afull_mode | input | 1 | Threshold select: 0 = half, 1 = seven-eighths |
| empty_n | output | 1 | Low when the FIFO is empty |
| full_n | output | 1 | Low when the FIFO is full |
| afull_n | output | 1 | Low at or above the selected threshold |
| bank_we | output | 1 | Write strobe to the lookup banks |
| bank_addr | output | 13 | Bank write index |
| bank_color | output | 24 | Bank write colour |
| pix_hold | output | 1 | Freeze request for the pixel output during a forced burst |

## Verification
Some properties are checked by assertions on every cycle:
- the bank strobe stays silent outside blanking unless a burst is running, and silent when the FIFO is empty;
- a burst always strobes the banks;
- a full FIFO stays full until something drains;
- the full flag always implies the threshold flag;
- a simultaneous push and drain keeps the occupancy steady.

Other behaviour only the directed scenarios can show:
- the ordering and integrity of the data;
- the exact threshold crossings in both modes;
- the burst being exactly four entries long;
- the pending word landing at the tail in the cycle after the burst.

// File: rtl/pal_wr_fifo.sv
module pal_wr_fifo #(
  parameter int DEPTH = 64,
  parameter int AW    = 13,
  parameter int CW    = 24,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [CW-1:0] push_color,
  input  logic          blank_n,
  input  logic          afull_mode,
  output logic          empty_n,
  output logic          full_n,
  output logic          afull_n,
  output logic          bank_we,
  output logic [AW-1:0] bank_addr,
  output logic [CW-1:0] bank_color,
  output logic          pix_hold
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = PW + 1;
  localparam int FW = $clog2(BURST + 1);
  localparam int EW = AW + CW;
  localparam logic [NW-1:0] HALF  = NW'(DEPTH / 2);
  localparam logic [NW-1:0] HIGH  = NW'(DEPTH - DEPTH / 8);
  localparam logic [NW-1:0] FULLC = NW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          pend_v;
  logic [EW-1:0] pend_d;

  wire is_full   = cnt == FULLC;
  wire is_empty  = cnt == '0;
  wire forcing   = fcnt != '0;
  wire trig      = push && is_full && !pend_v;
  wire pend_fire = pend_v && !forcing;
  wire wr        = (push && !is_full && !pend_v) || pend_fire;
  wire rd        = !is_empty && (forcing || !blank_n);
  wire [EW-1:0] wdata = pend_fire ? pend_d : {push_addr, push_color};

  always_ff @(posedge clk)
    if (wr) mem[wp] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      fcnt   <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      if (wr) wp <= wp + PW'(1);
      if (rd) rp <= rp + PW'(1);
      cnt <= cnt + NW'(wr) - NW'(rd);
      if (trig) begin
        fcnt   <= FW'(BURST);
        pend_v <= 1'b1;
        pend_d <= {push_addr, push_color};
      end else if (forcing) begin
        fcnt <= fcnt - FW'(1);
      end else if (pend_fire) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign empty_n = !is_empty;
  assign full_n  = !is_full;
  assign afull_n = !(cnt >= (afull_mode ? HIGH : HALF));
  assign bank_we = rd;
  assign {bank_addr, bank_color} = mem[rp];
  assign pix_hold = forcing;

  p_drain_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !pix_hold) |-> !bank_we);
  p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !bank_we);
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !bank_we) |=> !full_n);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);
  p_full_afull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  p_hold_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_hold |-> bank_we);
  p_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |=> cnt == $past(cnt));
endmodule

// File: tb/sim_pal_wr_fifo.sv
module sim_pal_wr_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 1'b0, blank_n = 1'b1, afull_mode = 1'b0;
  logic [12:0] push_addr = '0;
  logic [23:0] push_color = '0;
  logic empty_n, full_n, afull_n, bank_we, pix_hold;
  logic [12:0] bank_addr;
  logic [23:0] bank_color;
  int errs = 0, checks = 0;
  logic [36:0] q[$];

  always #4 clk = ~clk;

  pal_wr_fifo u0 (.clk, .rst_n, .push, .push_addr, .push_color, .blank_n,
    .afull_mode, .empty_n, .full_n, .afull_n, .bank_we, .bank_addr,
    .bank_color, .pix_hold);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [36:0] mk(input int i);
    return {13'(i * 7 + 3), 8'(i), 8'(~i), 8'(i * 3 + 1)};
  endfunction

  task automatic push_one(input logic [36:0] d);
    push = 1'b1;
    {push_addr, push_color} = d;
    @(negedge clk);
    push = 1'b0;
    q.push_back(d);
  endtask

  task automatic drain_check(input int n);
    blank_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk("R3", "bank_we while blanked", 64'(bank_we), 64'd1);
      chk("R2", "bank entry", 64'({bank_addr, bank_color}), 64'(q[0]));
      void'(q.pop_front());
      @(negedge clk);
    end
    blank_n = 1'b1;
    #1;
    chk("R3", "bank_we after blanking", 64'(bank_we), 64'd0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "empty_n", 64'(empty_n), 64'd0);
    chk("R1", "full_n", 64'(full_n), 64'd1);
    chk("R1", "afull_n", 64'(afull_n), 64'd1);
    chk("R1", "bank_we", 64'(bank_we), 64'd0);
    chk("R1", "pix_hold", 64'(pix_hold), 64'd0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) push_one(mk(100 + i));
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R3", "no drain while visible", 64'(bank_we), 64'd0);
      chk("R4", "empty_n with data", 64'(empty_n), 64'd1);
      @(negedge clk);
    end
    drain_check(5);
    chk("R4", "empty_n after drain", 64'(empty_n), 64'd0);
  endtask

  task automatic t_flags;
    afull_mode = 1'b0;
    for (int i = 0; i < 31; i++) push_one(mk(i));
    #1 chk("R6", "afull_n at 31 mode0", 64'(afull_n), 64'd1);
    push_one(mk(31));
    #1 chk("R6", "afull_n at 32 mode0", 64'(afull_n), 64'd0);
    afull_mode = 1'b1;
    #1 chk("R6", "afull_n at 32 mode1", 64'(afull_n), 64'd1);
    for (int i = 32; i < 55; i++) push_one(mk(i));
    #1 chk("R6", "afull_n at 55 mode1", 64'(afull_n), 64'd1);
    push_one(mk(55));
    #1 chk("R6", "afull_n at 56 mode1", 64'(afull_n), 64'd0);
    for (int i = 56; i < 63; i++) push_one(mk(i));
    #1 chk("R5", "full_n at 63", 64'(full_n), 64'd1);
    push_one(mk(63));
    for (int i = 0; i < 3; i++) begin
      #1 chk("R5", "full_n held at 64", 64'(full_n), 64'd0);
      @(negedge clk);
    end
    blank_n = 1'b0;
    #1;
    chk("R2", "single drain entry", 64'({bank_addr, bank_color}), 64'(q[0]));
    void'(q.pop_front());
    @(negedge clk);
    blank_n = 1'b1;
    #1 chk("R5", "full_n after one transfer", 64'(full_n), 64'd1);
    push_one(mk(64));
    #1 chk("R5", "full_n refilled", 64'(full_n), 64'd0);
  endtask

  task automatic t_force;
    logic [36:0] nw;
    nw = {13'h1ABC, 24'hC0FFEE};
    push = 1'b1;
    {push_addr, push_color} = nw;
    @(negedge clk);
    push = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R7", "pix_hold in burst", 64'(pix_hold), 64'd1);
      chk("R7", "forced bank_we", 64'(bank_we), 64'd1);
      chk("R7", "forced entry", 64'({bank_addr, bank_color}), 64'(q[0]));
      void'(q.pop_front());
      if (k == 1) begin
        push = 1'b1;
        {push_addr, push_color} = {13'h0555, 24'h123456};
      end
      @(negedge clk);
      push = 1'b0;
    end
    #1;
    chk("R7", "pix_hold after burst", 64'(pix_hold), 64'd0);
    chk("R3", "no drain after burst", 64'(bank_we), 64'd0);
    chk("R5", "full_n after burst", 64'(full_n), 64'd1);
    q.push_back(nw);
    @(negedge clk);
    #1 chk("R8", "full_n with pending stored", 64'(full_n), 64'd1);
    chk("R8", "occupancy after pending", 64'(q.size()), 64'd61);
    drain_check(61);
    chk("R8", "empty after burst tail", 64'(empty_n), 64'd0);
  endtask

  task automatic t_simul;
    for (int i = 0; i < 3; i++) push_one(mk(200 + i));
    blank_n = 1'b0;
    push = 1'b1;
    {push_addr, push_color} = mk(300);
    #1 chk("R9", "drain entry in overlap", 64'({bank_addr, bank_color}), 64'(q[0]));
    void'(q.pop_front());
    q.push_back(mk(300));
    @(negedge clk);
    push = 1'b0;
    blank_n = 1'b1;
    drain_check(3);
    chk("R9", "occupancy unchanged by overlap", 64'(empty_n), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_order();
    t_flags();
    t_force();
    t_simul();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule